// File: doc/BRIEF.md
# Compare Timer with Periodic Auto-Increment Event

This block is a memory-mapped physical timer that watches a free-running 64-bit system count supplied on an input. Software programs a 64-bit absolute compare value, either as two 32-bit halves or through a signed 32-bit relative view measured from the present count. A control register holds an enable bit, an interrupt mask bit and a read-only status bit. The interrupt output is driven from these three bits.

A second mode keeps its own 64-bit event time. When software turns the mode on, the event time is loaded with the present count plus a 32-bit reload interval. Each time the count reaches the event time, a sticky event flag is set and the event time moves forward by the interval. While this mode is on, the event flag drives the status bit in place of the compare result. Software clears the flag by writing zero to the clear bit of the mode register. Writes take effect at the clock edge on which `wr_en` is high. Reads are combinational on `addr`. Firing depends only on the count value, so a slower or paused counter delays firing by the same amount.

Top module: `evt_cmp_timer`

## Requirements
- R1: After reset, control (0x2C), compare (0x20/0x24), event time (0x40/0x44), reload (0x48), mode control (0x4C) and frequency (0x10) all read 0, and `irq` is low.
- R2: Offsets 0x00 and 0x04 return the low and high words of `sys_count`. Offset 0x10 is a plain 32-bit store that reads back the value last written.
- R3: Control bit 0 is enable and bit 1 is the interrupt mask. Both can be written. Bit 2 is status and cannot be written. Status reads as enable AND the active source, so control reads 0, 1, 5 or 7 in the cases exercised.
- R4: Offset 0x28 reads the low 32 bits of (compare − count). With compare 4000 and count 100 it reads 3900, and at the match point it reads 0.
- R5: When the event mode is off, the active source is the unsigned 64-bit test count ≥ compare. The high words take part in this test.
- R6: A write to 0x4C with bit 0 = 1 while the mode is off turns the mode on. The same write sets the event time to count + reload (zero-extended) and clears the flag. Writing bit 0 = 1 while the mode is already on does not reload the event time.
- R7: While the mode is on, the active source is the event flag. Control therefore reads 1 right after the mode is enabled, even when count is past compare.
- R8: While the mode is on and count ≥ event time, on the next edge the flag sets and the event time increases by the reload interval. The flag stays set until software clears it.
- R9: A write to 0x4C with bit 1 = 0 clears the flag. With bit 1 = 1 the flag is kept. Mode control reads bit 0 = mode enable and bit 1 = flag.
- R10: The count and event-time views carry correctly into their high words past 2^32.
- R11: A write of v to 0x28 sets compare to count + sign-extended v.
- R12: `irq` equals enable AND status AND NOT mask.
- R13: Firing follows the count input rather than elapsed cycles. At a reduced count rate, status rises on the first edge at which count equals compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_count | input | 64 | System count value |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Timer interrupt |

## Verification
The compare path is driven with a count that rises one step per cycle, with one that rises one step every sixteen cycles, and with jumps across the 2^32 boundary. These patterns separate a count-driven comparator from one that counts cycles, and a full 64-bit compare from a compare of the low word only. Both negative and positive relative writes are applied, which shows whether sign extension is correct. In event mode, writes are made with and without the clear bit and with the mode already on. These cases separate a reload on every enable write from a reload only on the off-to-on edge, and a sticky flag from one that follows the compare level. A behavioural model is compared against every read value and against `irq` on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned CNT_W  = 2 * REG_W;
    localparam int unsigned ADDR_W = 8;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [REG_W-1:0] word_t;

    typedef enum logic [ADDR_W-1:0] {
        OFS_CNT_LO = 8'h00,
        OFS_CNT_HI = 8'h04,
        OFS_FREQ   = 8'h10,
        OFS_CMP_LO = 8'h20,
        OFS_CMP_HI = 8'h24,
        OFS_REL    = 8'h28,
        OFS_CTRL   = 8'h2C,
        OFS_EVT_LO = 8'h40,
        OFS_EVT_HI = 8'h44,
        OFS_RELOAD = 8'h48,
        OFS_AICTL  = 8'h4C
    } reg_ofs_e;

    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_MASK_BIT = 1;
    localparam int unsigned CTRL_STAT_BIT = 2;
    localparam int unsigned AI_EN_BIT     = 0;
    localparam int unsigned AI_CLR_BIT    = 1;

    typedef struct packed {
        logic mask;
        logic en;
    } ctrl_t;

    function automatic cnt_t sext_word(input word_t w);
        return {{REG_W{w[REG_W-1]}}, w};
    endfunction

    function automatic cnt_t zext_word(input word_t w);
        return {{REG_W{1'b0}}, w};
    endfunction
endpackage

// File: rtl/tmr_compare.sv
module tmr_compare
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cnt_t  count,
    input  logic  wr_lo,
    input  logic  wr_hi,
    input  logic  wr_rel,
    input  word_t wdata,
    output cnt_t  cval,
    output logic  hit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cval <= '0;
        end else if (wr_rel) begin
            cval <= count + sext_word(wdata);
        end else begin
            if (wr_lo) cval[REG_W-1:0]     <= wdata;
            if (wr_hi) cval[CNT_W-1:REG_W] <= wdata;
        end
    end

    assign hit = (count >= cval);

    // R11
    rel_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_rel |=> cval == $past(count) + sext_word($past(wdata)));
endmodule

// File: rtl/tmr_autoinc.sv
module tmr_autoinc
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cnt_t  count,
    input  logic  wr_ctl,
    input  logic  wr_reload,
    input  word_t wdata,
    output logic  ai_en,
    output logic  flag,
    output cnt_t  evt,
    output word_t reload
);
    logic start;
    logic ev_hit;
    logic clr;

    assign start  = wr_ctl && wdata[AI_EN_BIT] && !ai_en;
    assign ev_hit = ai_en && (count >= evt);
    assign clr    = wr_ctl && (start || !wdata[AI_CLR_BIT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ai_en  <= 1'b0;
            flag   <= 1'b0;
            evt    <= '0;
            reload <= '0;
        end else begin
            if (wr_ctl)    ai_en  <= wdata[AI_EN_BIT];
            if (wr_reload) reload <= wdata;
            if (start)       evt <= count + zext_word(reload);
            else if (ev_hit) evt <= evt + zext_word(reload);
            if (clr)         flag <= 1'b0;
            else if (ev_hit) flag <= 1'b1;
        end
    end

    // R6
    ai_load_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (evt == $past(count) + zext_word($past(reload))) && !flag);
    // R8
    evt_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_hit && !start) |=> evt == $past(evt) + zext_word($past(reload)));
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !wr_ctl) |=> flag);
endmodule

// File: rtl/evt_cmp_timer.sv
module evt_cmp_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       sys_count,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);
    ctrl_t ctrl_q;
    word_t freq_q;
    cnt_t  cval;
    cnt_t  evt;
    word_t reload;
    logic  cmp_hit;
    logic  ai_en;
    logic  ai_flag;
    logic  status;

    function automatic logic wr_at(input reg_ofs_e ofs, input logic we, input logic [ADDR_W-1:0] a);
        return we && (a == ofs);
    endfunction

    tmr_compare u_cmp (
        .clk    (clk),
        .rst    (rst),
        .count  (sys_count),
        .wr_lo  (wr_at(OFS_CMP_LO, wr_en, addr)),
        .wr_hi  (wr_at(OFS_CMP_HI, wr_en, addr)),
        .wr_rel (wr_at(OFS_REL, wr_en, addr)),
        .wdata  (wdata),
        .cval   (cval),
        .hit    (cmp_hit)
    );

    tmr_autoinc u_ai (
        .clk       (clk),
        .rst       (rst),
        .count     (sys_count),
        .wr_ctl    (wr_at(OFS_AICTL, wr_en, addr)),
        .wr_reload (wr_at(OFS_RELOAD, wr_en, addr)),
        .wdata     (wdata),
        .ai_en     (ai_en),
        .flag      (ai_flag),
        .evt       (evt),
        .reload    (reload)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            freq_q <= '0;
        end else begin
            if (wr_at(OFS_CTRL, wr_en, addr)) begin
                ctrl_q.en   <= wdata[CTRL_EN_BIT];
                ctrl_q.mask <= wdata[CTRL_MASK_BIT];
            end
            if (wr_at(OFS_FREQ, wr_en, addr)) freq_q <= wdata;
        end
    end

    assign status = ctrl_q.en && (ai_en ? ai_flag : cmp_hit);
    assign irq    = status && !ctrl_q.mask;

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CNT_LO: rdata = sys_count[REG_W-1:0];
            OFS_CNT_HI: rdata = sys_count[CNT_W-1:REG_W];
            OFS_FREQ:   rdata = freq_q;
            OFS_CMP_LO: rdata = cval[REG_W-1:0];
            OFS_CMP_HI: rdata = cval[CNT_W-1:REG_W];
            OFS_REL:    rdata = cval[REG_W-1:0] - sys_count[REG_W-1:0];
            OFS_CTRL: begin
                rdata[CTRL_EN_BIT]   = ctrl_q.en;
                rdata[CTRL_MASK_BIT] = ctrl_q.mask;
                rdata[CTRL_STAT_BIT] = status;
            end
            OFS_EVT_LO: rdata = evt[REG_W-1:0];
            OFS_EVT_HI: rdata = evt[CNT_W-1:REG_W];
            OFS_RELOAD: rdata = reload;
            OFS_AICTL: begin
                rdata[AI_EN_BIT]  = ai_en;
                rdata[AI_CLR_BIT] = ai_flag;
            end
            default:    rdata = '0;
        endcase
    end

    // R5
    cmp_status_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.en && !ai_en && (sys_count >= cval) && !ctrl_q.mask) |-> irq);
    // R7
    ai_owns_status_chk: assert property (@(posedge clk) disable iff (rst)
        (ai_en && !ai_flag) |-> !irq);
    // R12
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl_q.en && !ctrl_q.mask));
endmodule

// File: tb/evt_cmp_timer_bench.sv
module evt_cmp_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] sys_count = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    evt_cmp_timer u_evt_cmp_timer (
        .clk(clk), .rst(rst), .sys_count(sys_count), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // behavioural reference state
    bit [63:0] m_cval, m_evt;
    bit [31:0] m_freq, m_reload;
    bit        m_en, m_mask, m_aien, m_flag;

    always @(posedge clk) begin
        bit start, evh, wai;
        if (rst) begin
            m_cval = 0; m_evt = 0; m_freq = 0; m_reload = 0;
            m_en = 0; m_mask = 0; m_aien = 0; m_flag = 0;
        end else begin
            wai   = wr_en && addr == 8'h4C;
            start = wai && wdata[0] && !m_aien;
            evh   = m_aien && (sys_count >= m_evt);
            if (start)    m_evt = sys_count + 64'(m_reload);
            else if (evh) m_evt = m_evt + 64'(m_reload);
            if (wai && (start || !wdata[1])) m_flag = 0;
            else if (evh) m_flag = 1;
            if (wai) m_aien = wdata[0];
            if (wr_en) begin
                case (addr)
                    8'h10: m_freq = wdata;
                    8'h20: m_cval[31:0] = wdata;
                    8'h24: m_cval[63:32] = wdata;
                    8'h28: m_cval = sys_count + {{32{wdata[31]}}, wdata};
                    8'h2C: begin m_en = wdata[0]; m_mask = wdata[1]; end
                    8'h48: m_reload = wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic bit m_stat();
        return m_en && (m_aien ? m_flag : (sys_count >= m_cval));
    endfunction

    function automatic bit [31:0] m_read(input bit [7:0] a);
        bit [31:0] t;
        case (a)
            8'h00: return sys_count[31:0];
            8'h04: return sys_count[63:32];
            8'h10: return m_freq;
            8'h20: return m_cval[31:0];
            8'h24: return m_cval[63:32];
            8'h28: begin t = m_cval[31:0] - sys_count[31:0]; return t; end
            8'h2C: return {29'd0, m_stat(), m_mask, m_en};
            8'h40: return m_evt[31:0];
            8'h44: return m_evt[63:32];
            8'h48: return m_reload;
            8'h4C: return {30'd0, m_flag, m_aien};
            default: return 32'd0;
        endcase
    endfunction

    // per-cycle comparison against the model (covers R1-R13 continuously)
    always @(negedge clk) begin
        if (!rst && !done) begin
            tests++;
            if (rdata !== m_read(addr)) begin
                fails++;
                $display("FAIL model R2 read addr %h: actual %h expected %h", addr, rdata, m_read(addr));
            end
            tests++;
            if (irq !== (m_stat() && !m_mask)) begin
                fails++;
                $display("FAIL model R12 irq: actual %b expected %b", irq, m_stat() && !m_mask);
            end
        end
    end

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(posedge clk); #1;
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic chk(input bit [7:0] a, input bit [31:0] exp, input string tag);
        @(posedge clk); #1;
        wr_en = 0; addr = a;
        @(negedge clk);
        tests++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s addr %h: actual %h expected %h", tag, a, rdata, exp);
        end
    endtask

    task automatic chk_irq(input bit exp, input string tag);
        @(negedge clk);
        tests++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq: actual %b expected %b", tag, irq, exp);
        end
    endtask

    task automatic advance(input int n, input int div);
        for (int i = 0; i < n; i++) begin
            repeat (div) @(posedge clk);
            #1 sys_count = sys_count + 1;
        end
    endtask

    task automatic set_count(input bit [63:0] v);
        @(posedge clk); #1 sys_count = v;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk(8'h2C, 32'd0, "R1 ctrl");
        chk(8'h24, 32'd0, "R1 cmp hi");
        chk(8'h40, 32'd0, "R1 evt lo");
        chk(8'h48, 32'd0, "R1 reload");
        chk(8'h4C, 32'd0, "R1 aictl");
        chk(8'h10, 32'd0, "R1 freq");
        chk_irq(0, "R1");
        // R2 count view and frequency store
        wr(8'h10, 32'h01E8_4800);
        chk(8'h10, 32'h01E8_4800, "R2 freq");
        wr(8'h2C, 1);
        advance(100, 1);
        chk(8'h00, 32'd100, "R2 cnt lo");
        chk(8'h04, 32'd0, "R2 cnt hi");
        // R4 relative view
        wr(8'h20, 4000);
        wr(8'h24, 0);
        chk(8'h28, 32'd3900, "R4 rel");
        chk(8'h2C, 32'd1, "R3 ctrl idle");
        advance(3900, 1);
        chk(8'h28, 32'd0, "R4 rel at match");
        chk(8'h2C, 32'd5, "R5 fired");
        chk_irq(1, "R12 unmasked");
        // R12 mask, R3 status not writable
        wr(8'h2C, 32'h7);
        chk(8'h2C, 32'd7, "R3 masked");
        chk_irq(0, "R12 masked");
        wr(8'h2C, 1);
        // R6/R7 auto-increment start
        wr(8'h48, 200);
        wr(8'h4C, 1);
        chk(8'h40, 32'd4200, "R6 evt load");
        chk(8'h44, 32'd0, "R6 evt hi");
        chk(8'h2C, 32'd1, "R7 flag owns status");
        advance(100, 1);
        chk(8'h2C, 32'd1, "R8 not yet");
        advance(100, 1);
        chk(8'h2C, 32'd5, "R8 event hit");
        chk(8'h40, 32'd4400, "R8 evt advance");
        advance(100, 1);
        chk(8'h2C, 32'd5, "R8 sticky");
        // R9 clear-bit semantics
        wr(8'h4C, 32'h3);
        chk(8'h2C, 32'd5, "R9 keep with bit1=1");
        chk(8'h4C, 32'd3, "R9 aictl read");
        wr(8'h4C, 32'h1);
        chk(8'h2C, 32'd1, "R9 cleared");
        chk(8'h40, 32'd4400, "R6 no reload when on");
        advance(100, 1);
        chk(8'h2C, 32'd5, "R8 fire again");
        chk(8'h40, 32'd4600, "R8 evt 4600");
        // R10 high-word carry
        wr(8'h4C, 0);
        set_count(64'h42_0000_0000 + 64'd4400);
        chk(8'h00, 32'd4400, "R10 cnt lo");
        chk(8'h04, 32'h42, "R10 cnt hi");
        wr(8'h4C, 1);
        chk(8'h40, 32'd4600, "R10 evt lo");
        chk(8'h44, 32'h42, "R10 evt hi");
        wr(8'h4C, 0);
        // R5 full 64-bit compare
        wr(8'h20, 0);
        wr(8'h24, 32'h43);
        chk(8'h2C, 32'd1, "R5 hi word blocks");
        wr(8'h24, 32'h42);
        chk(8'h2C, 32'd5, "R5 hi word equal");
        // R11 relative write
        wr(8'h28, 32'hFFFF_FFFB);
        chk(8'h28, 32'hFFFF_FFFB, "R11 negative rel");
        chk(8'h2C, 32'd5, "R11 past compare");
        wr(8'h28, 32'd10);
        chk(8'h2C, 32'd1, "R11 future compare");
        advance(9, 1);
        chk(8'h2C, 32'd1, "R11 one short");
        advance(1, 1);
        chk(8'h2C, 32'd5, "R11 reached");
        // R13 rate change
        set_count(64'd0);
        wr(8'h20, 4000);
        wr(8'h24, 0);
        advance(2000, 1);
        chk(8'h2C, 32'd1, "R13 halfway");
        advance(1999, 16);
        chk(8'h2C, 32'd1, "R13 one count short");
        advance(1, 16);
        chk(8'h2C, 32'd5, "R13 fired at count");
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule